// File: doc/BRIEF.md
# Bitfield Extract Execution Unit

This unit executes a small set of custom integer instructions. Each one reads a single source operand and returns a fixed bit field taken from it. The field is widened to the full register width with either its top bit or zeros. The field in bits [24:20] of the instruction word does not name a second register. It acts as a function select that chooses among six extractions: one lone bit, one unaligned byte and one 16-bit half. Each of the three fields comes in a signed and an unsigned variant.

The unit sits beside an integer pipeline. The pipeline presents an instruction word, the rs1 value and a valid strobe. One cycle later the unit returns a destination index, a result, a write-enable and an illegal flag, all from registers. The register width `XLEN` is 32 or 64.

Top module: `bfx_unit`

## Requirements
- R1: An instruction is claimed only when it meets all three of these conditions: bits [6:0] equal 7'b1111011, bits [14:12] equal 3'b000, and bits [31:25] are zero. Any other word leaves `we_o` and `illegal_o` low, and leaves `rd_o` and `result_o` unchanged.
- R2: Select value 0 (bits [24:20]) returns rs1 bit 23 copied into every result bit. Select value 1 returns rs1 bit 23 in bit 0, with all other bits zero.
- R3: Select 2 returns rs1[18:11] zero-extended. Select 3 returns rs1[18:11] extended with rs1[18].
- R4: Select 4 returns rs1[31:16] zero-extended. Select 5 returns rs1[31:16] extended with rs1[31]. At XLEN 32, these are a logical and an arithmetic right shift by 16.
- R5: When the rd field (bits [11:7]) is zero, `we_o` stays low, even for a valid claimed instruction.
- R6: For a claimed, legal instruction, `we_o` is high on the cycle after the `valid_i` edge and for that cycle only. `we_o` and `illegal_o` are never high unless `valid_i` was high on the previous edge. `rd_o` carries bits [11:7].
- R7: A claimed instruction with a select value from 6 to 31 raises `illegal_o` for one cycle. In that case `we_o` stays low and `result_o` is zero.
- R8: While `rst_ni` is low, `we_o`, `illegal_o`, `rd_o` and `result_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word and operand are valid |
| instr_i | input | 32 | Instruction word |
| rs1_i | input | XLEN | Source operand value |
| rd_o | output | 5 | Destination register index |
| result_o | output | XLEN | Extracted, extended result |
| we_o | output | 1 | Destination write-enable |
| illegal_o | output | 1 | Claimed instruction with an unknown select |

## Verification
Every result is due exactly one rising edge after the stimulus is presented. This applies to the write-enable, the illegal flag, the index and the data alike, because there is one register stage between the inputs and the outputs. The bench drives each instruction on a falling edge and drops the strobe on the next falling edge. It samples all outputs there, half a period after the capturing edge. One more idle cycle then shows that the write-enable and the illegal flag have returned low, which confirms each is a single-cycle pulse.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  localparam logic [6:0] OPC_CUSTOM = 7'b1111011;
  localparam logic [2:0] F3_EXT     = 3'b000;
  localparam logic [6:0] F7_EXT     = 7'b0000000;
  localparam int unsigned NUM_FIELDS = 3;
  localparam int unsigned NUM_SEL    = 6;

  typedef enum logic [2:0] {
    SEL_S_BIT  = 3'd0,
    SEL_Z_BIT  = 3'd1,
    SEL_Z_BYTE = 3'd2,
    SEL_S_BYTE = 3'd3,
    SEL_Z_HALF = 3'd4,
    SEL_S_HALF = 3'd5
  } sel_e;

  typedef struct packed {
    logic       hit;
    logic       legal;
    logic [4:0] rd;
    sel_e       sel;
  } dec_t;

  function automatic int unsigned fld_lsb(int unsigned idx);
    return (idx == 0) ? 23 : (idx == 1) ? 11 : 16;
  endfunction

  function automatic int unsigned fld_width(int unsigned idx);
    return (idx == 0) ? 1 : (idx == 1) ? 8 : 16;
  endfunction
endpackage

// File: rtl/bfx_decode.sv
module bfx_decode
  import bfx_pkg::*;
(
  input  logic [31:0] instr_i,
  output dec_t        dec_o
);
  logic [4:0] fsel;
  assign fsel = instr_i[24:20];

  always_comb begin
    dec_o.hit   = (instr_i[6:0] == OPC_CUSTOM) && (instr_i[14:12] == F3_EXT)
               && (instr_i[31:25] == F7_EXT);
    dec_o.legal = (fsel < 5'(NUM_SEL));
    dec_o.rd    = instr_i[11:7];
    dec_o.sel   = sel_e'(fsel[2:0]);
  end
endmodule

// File: rtl/bfx_extract.sv
module bfx_extract
  import bfx_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  sel_e            sel_i,
  input  logic [XLEN-1:0] rs1_i,
  output logic [XLEN-1:0] res_o
);
  logic [XLEN-1:0] zx [NUM_FIELDS];
  logic [XLEN-1:0] sx [NUM_FIELDS];

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
    localparam int unsigned LSB = fld_lsb(g);
    localparam int unsigned W   = fld_width(g);
    logic [W-1:0] fld;
    assign fld   = rs1_i[LSB +: W];
    assign zx[g] = {{(XLEN-W){1'b0}}, fld};
    assign sx[g] = {{(XLEN-W){fld[W-1]}}, fld};
  end

  always_comb begin
    unique case (sel_i)
      SEL_S_BIT:  res_o = sx[0];
      SEL_Z_BIT:  res_o = zx[0];
      SEL_Z_BYTE: res_o = zx[1];
      SEL_S_BYTE: res_o = sx[1];
      SEL_Z_HALF: res_o = zx[2];
      SEL_S_HALF: res_o = sx[2];
      default:    res_o = '0;
    endcase
  end
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
  import bfx_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] rs1_i,
  output logic [4:0]      rd_o,
  output logic [XLEN-1:0] result_o,
  output logic            we_o,
  output logic            illegal_o
);
  dec_t            dec;
  logic [XLEN-1:0] ext;
  logic            take;

  bfx_decode u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  bfx_extract #(.XLEN(XLEN)) u_ext (
    .sel_i (dec.sel),
    .rs1_i (rs1_i),
    .res_o (ext)
  );

  assign take = valid_i && dec.hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o      <= 1'b0;
      illegal_o <= 1'b0;
      rd_o      <= '0;
      result_o  <= '0;
    end else begin
      we_o      <= take && dec.legal && (dec.rd != 5'd0);
      illegal_o <= take && !dec.legal;
      if (take) begin
        rd_o     <= dec.rd;
        result_o <= dec.legal ? ext : '0;
      end
    end
  end
endmodule

// File: rtl/bfx_unit_chk.sv
module bfx_unit_chk #(
  parameter int unsigned XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [31:0]     instr_i,
  input logic [XLEN-1:0] rs1_i,
  input logic [4:0]      rd_o,
  input logic [XLEN-1:0] result_o,
  input logic            we_o,
  input logic            illegal_o
);
  a_r6_we_after_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o || illegal_o) |-> $past(valid_i));

  a_r7_not_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!we_o && result_o == '0 && $past(instr_i[24:20]) > 5'd5));

  a_r5_rd_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> (rd_o != 5'd0));

  a_r2_sbit_uniform: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && $past(instr_i[24:20]) == 5'd0) |-> (result_o == '0 || result_o == '1));

  a_r2_zbit_narrow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && $past(instr_i[24:20]) == 5'd1) |-> (result_o[XLEN-1:1] == '0));

  a_r1_ignore_other: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[6:0] != 7'b1111011) |=> (!we_o && !illegal_o && $stable(result_o)));

  a_r8_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (!we_o && !illegal_o && rd_o == '0 && result_o == '0));
endmodule

bind bfx_unit bfx_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/tb_bfx_unit.sv
module tb_bfx_unit;
  localparam int XLEN = 64;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            valid_i = 1'b0;
  logic [31:0]     instr_i = '0;
  logic [XLEN-1:0] rs1_i = '0;
  logic [4:0]      rd_o;
  logic [XLEN-1:0] result_o;
  logic            we_o;
  logic            illegal_o;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  bfx_unit #(.XLEN(XLEN)) dut (.*);

  function automatic logic [63:0] exp_res(logic [4:0] s, logic [63:0] v);
    case (s)
      5'd0: return {64{v[23]}};
      5'd1: return {63'b0, v[23]};
      5'd2: return {56'b0, v[18:11]};
      5'd3: return {{56{v[18]}}, v[18:11]};
      5'd4: return {48'b0, v[31:16]};
      5'd5: return {{48{v[31]}}, v[31:16]};
      default: return 64'b0;
    endcase
  endfunction

  function automatic logic [31:0] mk(logic [4:0] s, logic [4:0] rd);
    return {7'b0, s, 5'd9, 3'b000, rd, 7'b1111011};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive on negedge, capture at posedge, sample at following negedge
  task automatic issue(logic [31:0] ins, logic [63:0] v);
    logic hit, legal;
    logic [4:0] s, rd;
    logic [63:0] prev_res;
    logic [4:0]  prev_rd;
    prev_res = result_o;
    prev_rd  = rd_o;
    hit   = (ins[6:0] == 7'b1111011) && (ins[14:12] == 3'b000) && (ins[31:25] == 7'b0);
    s     = ins[24:20];
    rd    = ins[11:7];
    legal = (s < 5'd6);
    instr_i = ins; rs1_i = v; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    if (!hit) begin
      chk("R1 we", {63'b0, we_o}, 64'd0);
      chk("R1 illegal", {63'b0, illegal_o}, 64'd0);
      chk("R1 result held", result_o, prev_res);
      chk("R1 rd held", {59'b0, rd_o}, {59'b0, prev_rd});
    end else if (!legal) begin
      chk("R7 illegal", {63'b0, illegal_o}, 64'd1);
      chk("R7 we", {63'b0, we_o}, 64'd0);
      chk("R7 result", result_o, 64'd0);
    end else begin
      chk(rd == 0 ? "R5 we" : "R6 we", {63'b0, we_o}, {63'b0, rd != 0});
      chk("R6 illegal", {63'b0, illegal_o}, 64'd0);
      chk("R6 rd", {59'b0, rd_o}, {59'b0, rd});
      chk(s < 2 ? "R2 result" : s < 4 ? "R3 result" : "R4 result", result_o, exp_res(s, v));
    end
    @(negedge clk_i);
    chk("R6 pulse", {62'b0, we_o, illegal_o}, 64'd0);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk_i);
    chk("R8 we", {63'b0, we_o}, 64'd0);
    chk("R8 illegal", {63'b0, illegal_o}, 64'd0);
    chk("R8 result", result_o, 64'd0);
    chk("R8 rd", {59'b0, rd_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // directed corners
    issue(mk(5'd0, 5'd1), 64'h0000_0000_0080_0000); // R2 bit set
    issue(mk(5'd0, 5'd2), 64'hFFFF_FFFF_FF7F_FFFF); // R2 bit clear
    issue(mk(5'd1, 5'd3), 64'hFFFF_FFFF_FFFF_FFFF); // R2
    issue(mk(5'd3, 5'd4), 64'h0000_0000_0004_0000); // R3 sign bit only
    issue(mk(5'd2, 5'd5), 64'hFFFF_FFFF_FFFF_FFFF); // R3
    issue(mk(5'd5, 5'd6), 64'h0000_0000_8000_0000); // R4
    issue(mk(5'd4, 5'd7), 64'hFFFF_FFFF_8001_0000); // R4
    issue(mk(5'd2, 5'd0), 64'h1234_5678_9ABC_DEF0); // R5
    issue(mk(5'd6, 5'd8), 64'h1);                   // R7 lowest
    issue(mk(5'd31, 5'd8), 64'h1);                  // R7 highest
    issue(mk(5'd0, 5'd9) | 32'h0200_0000, 64'hF);   // R1 funct7
    issue(mk(5'd0, 5'd9) | 32'h0000_1000, 64'hF);   // R1 funct3
    issue(mk(5'd0, 5'd9) ^ 32'h1, 64'hF);           // R1 opcode
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ins;
      logic [63:0] v;
      v   = {$urandom, $urandom};
      ins = mk(5'($urandom_range(0, 7)), 5'($urandom));
      if ($urandom_range(0, 9) == 0) ins = $urandom;
      if ($urandom_range(0, 9) == 0) ins[31:25] = 7'($urandom);
      issue(ins, v);
    end
    done = 1;
  end

  always @(posedge clk_i) begin
    cyc++;
    if (!done && cyc > 50000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog act=%0d exp<50000", cyc);
      done = 1;
    end
  end

  initial begin
    wait (done);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule